// File: doc/BRIEF.md
# Prioritized Error Recovery Classifier

This block watches a vector of fault-detector lines and turns the first one that fires into exactly one recovery action. When any detector is active and the block is idle, the lowest-numbered active detector is captured. Its number, the processor it belongs to and its recovery class are held, and the block locks. Every other report is then ignored until a recovery-complete handshake releases the lock.

Each detector has a configuration entry that gives a 3-bit class code and the index of its processor. There are five classes, ordered from least to most severe: correctable (0), processor retry (1), processor instruction damage (2), processor checkstop (3) and system stop (4). Codes 5 to 7 saturate to system stop. A per-class escalation mask can raise a class by one step, and a global override forces every error to system stop. Escalation can only raise a class.

The action comes out as a one-cycle strobe on one of five lines. A correctable error only raises its strobe as an indication. An instruction-damage or checkstop action fires at once. A retry action first waits until the store queue of the owning processor reports empty. A system-stop action also sets a clock-stop level that stays set until reset.

Top module: `recov_classifier`

## Requirements
- R1: After reset the block is unlocked, all action strobes and `clk_stop_o` are low, every detector entry holds class 0 and processor 0, and the escalation mask and override are clear.
- R2: When unlocked and one or more bits of `det_i` are high at a clock edge, the lowest-numbered active detector is captured. From that edge `locked_o` is high and `err_id_o`, `err_cpu_o` and `err_class_o` show the captured detector, its processor and its effective class.
- R3: While locked, activity on `det_i` has no effect. The captured outputs hold, and no further strobe appears.
- R4: Class codes are 0 correctable, 1 retry, 2 instruction damage, 3 processor checkstop and 4 system stop, and codes 5 to 7 act as 4. Strobe bits map to classes in the order ce, retry, ipd, cpuchk, sysstop. Exactly one strobe pulses for a single cycle per captured error. For every class except retry, the pulse comes in the cycle right after the capturing edge.
- R5: A retry action pulses `act_retry_o` only in the cycle after an edge at which `st_empty_i[err_cpu_o]` is high. That edge is at the earliest the one after capture, and the block stays locked, with no strobe, for as long as that bit is low.
- R6: Instruction-damage and both checkstop actions do not wait for `st_empty_i`.
- R7: Control register bit c (c = 0..4) of the escalation mask raises class c by exactly one step. It is applied once and never lowers a class, and system stop stays system stop.
- R8: Control register bit 5 (global override) makes every captured error class 4.
- R9: A class-4 action sets `clk_stop_o` from the capturing edge. It stays set through the recovery handshake and clears only on reset.
- R10: `rec_done_i` releases the lock only after the action strobe has been issued, and it is ignored while a retry is still waiting. A detector that is active at the first edge after release is captured.
- R11: A write with `cfg_we_i` high at address d < N_DET stores bits [2:0] as the class code and bits [3+:CPU_W] as the processor of detector d. Address N_DET stores the escalation mask in bits [4:0] and the override in bit 5, and other addresses change nothing. A write takes effect after its edge, so a detector captured at the same edge uses the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | CFG_AW | Configuration register address |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| det_i | input | N_DET | Fault-detector lines |
| st_empty_i | input | N_CPU | Per-processor store queue empty |
| rec_done_i | input | 1 | Recovery complete handshake |
| locked_o | output | 1 | An error is captured and being handled |
| err_id_o | output | ID_W | Captured detector number |
| err_cpu_o | output | CPU_W | Processor of the captured detector |
| err_class_o | output | 3 | Effective class of the captured error |
| act_ce_o | output | 1 | Correctable-error indication strobe |
| act_retry_o | output | 1 | Processor reset for retry strobe |
| act_ipd_o | output | 1 | Immediate processor reset strobe |
| act_cpuchk_o | output | 1 | Processor checkstop strobe |
| act_sysstop_o | output | 1 | System stop strobe |
| clk_stop_o | output | 1 | Sticky stop-all-clocks level |

## Verification
Two things can land on the same edge: a configuration write and a detector capture that read the same entry, and a detector firing while a previous error still holds the lock or is being released. The bench drives a write to a detector's entry on the same edge that the detector fires, and expects the class that was in force before the write. It also holds detector lines high across a locked period and through the cycle of `rec_done_i`, and expects the captured number to hold until release and no second strobe to appear.

// File: rtl/recov_pkg.sv
package recov_pkg;

    typedef enum logic [2:0] {
        CL_CE      = 3'd0,
        CL_RETRY   = 3'd1,
        CL_IPD     = 3'd2,
        CL_CPUCHK  = 3'd3,
        CL_SYSSTOP = 3'd4
    } rclass_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DRAIN = 2'd1,
        S_WAIT  = 2'd2
    } rstate_e;

    localparam int NUM_CLASSES = 5;

    // Map a raw 3-bit code onto the ordered classes; out-of-range codes saturate upward.
    function automatic rclass_e norm_class(input logic [2:0] code);
        return (code > 3'd4) ? CL_SYSSTOP : rclass_e'(code);
    endfunction

    // One escalation step per masked class, then the global override.
    function automatic rclass_e escalate(input rclass_e c, input logic [NUM_CLASSES-1:0] mask,
                                         input logic ovr);
        rclass_e r;
        r = c;
        if (mask[c] && (c != CL_SYSSTOP))
            r = rclass_e'(c + 3'd1);
        if (ovr)
            r = CL_SYSSTOP;
        return r;
    endfunction

endpackage

// File: rtl/recov_cfg_regs.sv
module recov_cfg_regs
    import recov_pkg::*;
#(
    parameter int N_DET = 8,
    parameter int CPU_W = 2,
    parameter int AW    = 4,
    parameter int DW    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [N_DET-1:0][2:0]       code_tab,
    output logic [N_DET-1:0][CPU_W-1:0] cpu_tab,
    output logic [NUM_CLASSES-1:0]      esc_mask,
    output logic                        ovr
);
    localparam int CTRL_ADDR = N_DET;

    for (genvar d = 0; d < N_DET; d++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                code_tab[d] <= '0;
                cpu_tab[d]  <= '0;
            end else if (we && (addr == AW'(d))) begin
                code_tab[d] <= wdata[2:0];
                cpu_tab[d]  <= wdata[3 +: CPU_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_mask <= '0;
            ovr      <= 1'b0;
        end else if (we && (addr == AW'(CTRL_ADDR))) begin
            esc_mask <= wdata[NUM_CLASSES-1:0];
            ovr      <= wdata[NUM_CLASSES];
        end
    end
endmodule

// File: rtl/recov_pick.sv
module recov_pick
    import recov_pkg::*;
#(
    parameter int N_DET = 8,
    parameter int CPU_W = 2,
    parameter int ID_W  = 3
) (
    input  logic [N_DET-1:0]            det,
    input  logic [N_DET-1:0][2:0]       code_tab,
    input  logic [N_DET-1:0][CPU_W-1:0] cpu_tab,
    input  logic [NUM_CLASSES-1:0]      esc_mask,
    input  logic                        ovr,
    output logic                        hit,
    output logic [ID_W-1:0]             id,
    output logic [CPU_W-1:0]            cpu,
    output rclass_e                     cls
);
    logic [2:0] code;

    // Scan from the top down so the lowest active index is the last to assign.
    always_comb begin
        id   = '0;
        cpu  = '0;
        code = '0;
        for (int i = N_DET - 1; i >= 0; i--) begin
            if (det[i]) begin
                id   = ID_W'(i);
                cpu  = cpu_tab[i];
                code = code_tab[i];
            end
        end
    end

    assign hit = |det;
    assign cls = escalate(norm_class(code), esc_mask, ovr);
endmodule

// File: rtl/recov_seq.sv
module recov_seq
    import recov_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int CPU_W = 2,
    parameter int ID_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hit,
    input  logic [ID_W-1:0]        id,
    input  logic [CPU_W-1:0]       cpu,
    input  rclass_e                cls,
    input  logic [N_CPU-1:0]       st_empty,
    input  logic                   rec_done,
    output logic                   locked,
    output logic [ID_W-1:0]        err_id,
    output logic [CPU_W-1:0]       err_cpu,
    output rclass_e                err_class,
    output logic [NUM_CLASSES-1:0] acts,
    output logic                   clk_stop
);
    rstate_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            err_id    <= '0;
            err_cpu   <= '0;
            err_class <= CL_CE;
            acts      <= '0;
            clk_stop  <= 1'b0;
        end else begin
            acts <= '0;
            case (state)
                S_IDLE: begin
                    if (hit) begin
                        err_id    <= id;
                        err_cpu   <= cpu;
                        err_class <= cls;
                        if (cls == CL_RETRY) begin
                            state <= S_DRAIN;
                        end else begin
                            state     <= S_WAIT;
                            acts[cls] <= 1'b1;
                        end
                        if (cls == CL_SYSSTOP)
                            clk_stop <= 1'b1;
                    end
                end
                S_DRAIN: begin
                    if (st_empty[err_cpu]) begin
                        acts[CL_RETRY] <= 1'b1;
                        state          <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (rec_done)
                        state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign locked = (state != S_IDLE);
endmodule

// File: rtl/recov_classifier.sv
module recov_classifier
    import recov_pkg::*;
#(
    parameter int N_DET  = 8,
    parameter int N_CPU  = 4,
    localparam int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int ID_W   = (N_DET > 1) ? $clog2(N_DET) : 1,
    localparam int CFG_AW = $clog2(N_DET + 1),
    localparam int CFG_DW = ((3 + CPU_W) > (NUM_CLASSES + 1)) ? (3 + CPU_W) : (NUM_CLASSES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    input  logic [N_DET-1:0]  det_i,
    input  logic [N_CPU-1:0]  st_empty_i,
    input  logic              rec_done_i,
    output logic              locked_o,
    output logic [ID_W-1:0]   err_id_o,
    output logic [CPU_W-1:0]  err_cpu_o,
    output logic [2:0]        err_class_o,
    output logic              act_ce_o,
    output logic              act_retry_o,
    output logic              act_ipd_o,
    output logic              act_cpuchk_o,
    output logic              act_sysstop_o,
    output logic              clk_stop_o
);
    logic [N_DET-1:0][2:0]       code_tab;
    logic [N_DET-1:0][CPU_W-1:0] cpu_tab;
    logic [NUM_CLASSES-1:0]      esc_mask;
    logic                        ovr;
    logic                        hit;
    logic [ID_W-1:0]             pick_id;
    logic [CPU_W-1:0]            pick_cpu;
    rclass_e                     pick_cls;
    rclass_e                     err_class;
    logic [NUM_CLASSES-1:0]      acts;

    recov_cfg_regs #(.N_DET(N_DET), .CPU_W(CPU_W), .AW(CFG_AW), .DW(CFG_DW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we_i),
        .addr     (cfg_addr_i),
        .wdata    (cfg_wdata_i),
        .code_tab (code_tab),
        .cpu_tab  (cpu_tab),
        .esc_mask (esc_mask),
        .ovr      (ovr)
    );

    recov_pick #(.N_DET(N_DET), .CPU_W(CPU_W), .ID_W(ID_W)) u_pick (
        .det      (det_i),
        .code_tab (code_tab),
        .cpu_tab  (cpu_tab),
        .esc_mask (esc_mask),
        .ovr      (ovr),
        .hit      (hit),
        .id       (pick_id),
        .cpu      (pick_cpu),
        .cls      (pick_cls)
    );

    recov_seq #(.N_CPU(N_CPU), .CPU_W(CPU_W), .ID_W(ID_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .id        (pick_id),
        .cpu       (pick_cpu),
        .cls       (pick_cls),
        .st_empty  (st_empty_i),
        .rec_done  (rec_done_i),
        .locked    (locked_o),
        .err_id    (err_id_o),
        .err_cpu   (err_cpu_o),
        .err_class (err_class),
        .acts      (acts),
        .clk_stop  (clk_stop_o)
    );

    assign err_class_o   = err_class;
    assign act_ce_o      = acts[CL_CE];
    assign act_retry_o   = acts[CL_RETRY];
    assign act_ipd_o     = acts[CL_IPD];
    assign act_cpuchk_o  = acts[CL_CPUCHK];
    assign act_sysstop_o = acts[CL_SYSSTOP];
endmodule

// File: rtl/recov_classifier_chk.sv
module recov_classifier_chk #(
    parameter int N_DET  = 8,
    parameter int N_CPU  = 4,
    localparam int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int ID_W   = (N_DET > 1) ? $clog2(N_DET) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CPU-1:0]  st_empty_i,
    input logic              locked_o,
    input logic [ID_W-1:0]   err_id_o,
    input logic [CPU_W-1:0]  err_cpu_o,
    input logic              act_ce_o,
    input logic              act_retry_o,
    input logic              act_ipd_o,
    input logic              act_cpuchk_o,
    input logic              act_sysstop_o,
    input logic              clk_stop_o
);
    logic [4:0] strobes;
    assign strobes = {act_sysstop_o, act_cpuchk_o, act_ipd_o, act_retry_o, act_ce_o};

    // R4: never more than one action line at a time
    a_r4_one_action: assert property (@(posedge clk) disable iff (rst) $onehot0(strobes));

    // R4: each strobe lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|strobes) |=> (strobes == 5'd0));

    // R3: the captured detector is held while locked
    a_r3_id_hold: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> $stable(err_id_o));

    // R5: retry reset only after the owning store queue was seen empty
    a_r5_drain_first: assert property (@(posedge clk) disable iff (rst)
        act_retry_o |-> $past(st_empty_i[err_cpu_o]));

    // R9: clock stop is sticky until reset
    a_r9_stop_sticky: assert property (@(posedge clk) disable iff (rst)
        clk_stop_o |=> clk_stop_o);

    // R10: strobes only occur while an error is held
    a_r10_strobe_locked: assert property (@(posedge clk) disable iff (rst)
        (|strobes) |-> locked_o);
endmodule

bind recov_classifier recov_classifier_chk #(.N_DET(N_DET), .N_CPU(N_CPU)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_empty_i    (st_empty_i),
    .locked_o      (locked_o),
    .err_id_o      (err_id_o),
    .err_cpu_o     (err_cpu_o),
    .act_ce_o      (act_ce_o),
    .act_retry_o   (act_retry_o),
    .act_ipd_o     (act_ipd_o),
    .act_cpuchk_o  (act_cpuchk_o),
    .act_sysstop_o (act_sysstop_o),
    .clk_stop_o    (clk_stop_o)
);

// File: tb/sim_recov_classifier.sv
module sim_recov_classifier;
    localparam int N_DET = 8;
    localparam int N_CPU = 4;
    localparam int CPU_W = 2;
    localparam int ID_W  = 3;
    localparam int AW    = 4;
    localparam int DW    = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [DW-1:0]    cfg_wdata = '0;
    logic [N_DET-1:0] det = '0;
    logic [N_CPU-1:0] st_empty = '1;
    logic             rec_done = 1'b0;
    logic             locked;
    logic [ID_W-1:0]  err_id;
    logic [CPU_W-1:0] err_cpu;
    logic [2:0]       err_class;
    logic             a_ce, a_retry, a_ipd, a_cpuchk, a_sys, clk_stop;

    recov_classifier #(.N_DET(N_DET), .N_CPU(N_CPU)) u0 (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .det_i(det), .st_empty_i(st_empty), .rec_done_i(rec_done), .locked_o(locked),
        .err_id_o(err_id), .err_cpu_o(err_cpu), .err_class_o(err_class),
        .act_ce_o(a_ce), .act_retry_o(a_retry), .act_ipd_o(a_ipd), .act_cpuchk_o(a_cpuchk),
        .act_sysstop_o(a_sys), .clk_stop_o(clk_stop)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int m_cls[N_DET];
    int m_cpu[N_DET];
    int m_mask = 0;
    int m_ovr  = 0;
    bit m_stop = 0;

    function automatic int eff(int d);
        int c;
        c = (m_cls[d] > 4) ? 4 : m_cls[d];
        if ((((m_mask >> c) & 1) == 1) && c < 4) c = c + 1;
        if (m_ovr != 0) c = 4;
        return c;
    endfunction

    function automatic int lowest(logic [N_DET-1:0] v);
        for (int i = 0; i < N_DET; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int strobes();
        return int'({a_sys, a_cpuchk, a_ipd, a_retry, a_ce});
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = DW'(d);
        tick();
        cfg_we = 1'b0;
        if (a < N_DET) begin
            m_cls[a] = d & 7;
            m_cpu[a] = (d >> 3) & 3;
        end else if (a == N_DET) begin
            m_mask = d & 31;
            m_ovr  = (d >> 5) & 1;
        end
    endtask

    task automatic release_lock(string req);
        rec_done = 1'b1;
        tick();
        rec_done = 1'b0;
        chk({req, " unlock"}, int'(locked), 0);
        chk({req, " no strobe"}, strobes(), 0);
    endtask

    // Fire a detector pattern from the idle state and check the capture and action.
    task automatic fire(logic [N_DET-1:0] v, string req);
        int d, c;
        det = v;
        tick();
        det = '0;
        d = lowest(v);
        c = eff(d);
        if (c == 4) m_stop = 1;
        chk({req, " id"}, int'(err_id), d);
        chk({req, " cpu"}, int'(err_cpu), m_cpu[d]);
        chk({req, " class"}, int'(err_class), c);
        chk({req, " locked"}, int'(locked), 1);
        chk({req, " R9 clk_stop"}, int'(clk_stop), int'(m_stop));
        if (c != 1) begin
            chk({req, " strobe"}, strobes(), 1 << c);
        end else begin
            chk({req, " R5 no early retry"}, strobes(), 0);
            tick();
            chk({req, " R5 retry strobe"}, strobes(), 2);
        end
        release_lock(req);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N_DET; i++) begin m_cls[i] = 0; m_cpu[i] = 0; end
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 locked", int'(locked), 0);
        chk("R1 strobes", strobes(), 0);
        chk("R1 clk_stop", int'(clk_stop), 0);
        fire(8'b1000_0001, "R1 default entry");

        // R11 configuration, R2 lowest wins
        cfg_wr(1, (2 << 3) | 2);
        cfg_wr(2, (1 << 3) | 3);
        cfg_wr(3, (3 << 3) | 1);
        cfg_wr(4, (0 << 3) | 6);
        fire(8'b0000_0110, "R2 lowest");
        fire(8'b1010_0100, "R2 lowest mixed");

        // R3 lock: other detectors ignored while held
        det = 8'b0000_0100;
        tick();
        det = 8'b0000_0001;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R3 id held", int'(err_id), 2);
            chk("R3 no extra strobe", strobes(), 0);
        end
        // R10 release with a detector still active: recaptured after release
        rec_done = 1'b1;
        tick();
        rec_done = 1'b0;
        chk("R10 release", int'(locked), 0);
        tick();
        det = '0;
        chk("R10 recapture id", int'(err_id), 0);
        chk("R10 recapture strobe", strobes(), 1);
        release_lock("R10");

        // R5 retry waits for the owning store queue; R10 done ignored while draining
        st_empty = 4'b0111;
        det = 8'b0000_1000;
        tick();
        det = '0;
        chk("R5 class retry", int'(err_class), 1);
        for (int k = 0; k < 4; k++) begin
            rec_done = (k == 1);
            tick();
            chk("R5 waiting no strobe", strobes(), 0);
            chk("R10 still locked while draining", int'(locked), 1);
        end
        rec_done = 1'b0;
        st_empty = 4'b1000;
        tick();
        chk("R5 retry after empty", strobes(), 2);
        st_empty = '1;
        release_lock("R5");

        // R6 damage and checkstop ignore store queues
        st_empty = '0;
        fire(8'b0000_0010, "R6 ipd");
        fire(8'b0000_0100, "R6 cpuchk");
        st_empty = '1;

        // R4 saturated code
        fire(8'b0001_0000, "R4 code6");
        m_stop = 1;

        // R7 escalation: one step only
        cfg_wr(N_DET, 5'b00010);
        fire(8'b0000_1000, "R7 retry to ipd");
        cfg_wr(N_DET, 5'b00011);
        fire(8'b0000_0001, "R7 ce to retry once");
        cfg_wr(N_DET, 0);

        // R11 same-edge write and capture uses the old entry
        cfg_we = 1'b1; cfg_addr = 0; cfg_wdata = DW'(3);
        det = 8'b0000_0001;
        tick();
        cfg_we = 1'b0; det = '0;
        chk("R11 old class at same edge", int'(err_class), eff(0));
        release_lock("R11");
        m_cls[0] = 3;
        fire(8'b0000_0001, "R11 new class");
        cfg_wr(15, 6'h3F);
        fire(8'b0000_0001, "R11 bad address ignored");

        // R8 override, R9 sticky stop
        cfg_wr(N_DET, 6'b100000);
        fire(8'b0000_0010, "R8 override");
        chk("R9 stop after done", int'(clk_stop), 1);
        cfg_wr(N_DET, 0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [N_DET-1:0] v;
            if (n % 3 == 0) cfg_wr($urandom_range(N_DET - 1), $urandom_range(31));
            if (n % 7 == 0) cfg_wr(N_DET, $urandom_range(31));
            v = N_DET'($urandom_range(255));
            if (v == '0) v = 8'b0100_0000;
            fire(v, "R4 random");
        end

        // R9 reset clears stop, R1 after reset
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R9 stop cleared by reset", int'(clk_stop), 0);
        chk("R1 unlocked after reset", int'(locked), 0);
        m_stop = 0; m_mask = 0; m_ovr = 0;
        for (int i = 0; i < N_DET; i++) begin m_cls[i] = 0; m_cpu[i] = 0; end
        fire(8'b0010_0000, "R1 cleared entry");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule